// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This block is a 32-bit bitfield datapath with one register stage at its output. It performs one of two operations on each valid input. Extract pulls a field out of operand A and returns it either zero-filled or sign-filled above the field. Insert writes the low bits of operand A into a field of operand C and leaves every other bit of C as it was. For extract, operand A can first be mirrored end to end, so that the field is taken from the reversed word.

The field is described by one control operand, B. Its least significant byte holds the starting bit of the field and the next byte holds the field width. All other bits of B are ignored. A field that runs past bit 31 is cut short at bit 31. A field that starts at bit 32 or above selects no bits at all. The computed value is captured one clock after a valid input, and a strobe marks that cycle.

Top module: `bitfield_unit`

## Requirements
- R1: The field start is ctrl_b[7:0] and the field width is ctrl_b[15:8], both unsigned. Bits ctrl_b[31:16] have no effect on the result.
- R2: With op_insert = 0 and signed_en = 0, the result holds the selected field of the source in its low bits and zeros above it.
- R3: With op_insert = 0, signed_en = 1 and a nonzero width, every result bit above the field is a copy of the field's most significant bit, counted after truncation.
- R4: With op_insert = 0 and reverse_en = 1, the source is opnd_a mirrored so that source bit i equals opnd_a[31-i]. reverse_en has no effect when op_insert = 1.
- R5: With op_insert = 1, field bit i of the result equals opnd_a[i], and every result bit outside the field equals the same bit of opnd_c.
- R6: A width of zero makes extract return 0, in both signed and unsigned modes, and makes insert return opnd_c unchanged.
- R7: When start plus width exceeds 32, the field covers only bits start through 31, in both operations.
- R8: A start of 32 or more makes unsigned extract return 0, makes signed extract with a nonzero width return 32 copies of source bit 31, and makes insert return opnd_c.
- R9: valid_out is valid_in delayed by one clock. result is loaded only in a cycle where valid_in is high, and it holds its value otherwise.
- R10: While rst_n is low, valid_out and result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operands and controls are valid this cycle |
| op_insert | input | 1 | 0 = extract, 1 = insert |
| signed_en | input | 1 | Extract fills the bits above the field with its top bit |
| reverse_en | input | 1 | Extract reads from the mirrored opnd_a |
| opnd_a | input | 32 | Source word for extract; field bits for insert |
| ctrl_b | input | 32 | Field start in [7:0], field width in [15:8] |
| opnd_c | input | 32 | Base word for insert |
| result | output | 32 | Registered result |
| valid_out | output | 1 | result was loaded on the previous edge |

## Verification
Extract is tried with fields in the middle of the word, at bit 0 and reaching bit 31. Each field is run with its top bit both clear and set, so the zero fill and the sign fill give different results. Reversed extracts use asymmetric words, which separates a correct mirror from a missing or wrong one. Reverse is also set during an insert to show that it has no effect there. Insert uses a base word with alternating bits, so that any change outside the field shows up. The edge patterns are width zero, a field that runs past bit 31, and starts of 32 and 255. Each edge case is run in every mode, because unsigned, signed and insert treat it in different ways. Changing only the upper half of the control word shows whether it leaks into the result, and idle cycles between operations show whether the output register holds its value.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  typedef enum logic {
    BFU_OP_EXTRACT = 1'b0,
    BFU_OP_INSERT  = 1'b1
  } bfu_op_e;

  // Number of field bits that actually land inside a word of dw bits.
  function automatic int bfu_eff_width(int start, int width, int dw);
    if (width == 0 || start >= dw) return 0;
    if (start + width > dw) return dw - start;
    return width;
  endfunction

  // Index of the bit that carries the sign: the top bit of the truncated
  // field, or the top bit of the word when the field is empty.
  function automatic int bfu_sign_index(int start, int eff, int dw);
    if (eff == 0) return dw - 1;
    return start + eff - 1;
  endfunction

endpackage

// File: rtl/bfu_bit_reverse.sv
module bfu_bit_reverse #(
  parameter int DATA_W = 32
) (
  input  logic              enable,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_out
);

  logic [DATA_W-1:0] mirrored;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mirror
    assign mirrored[g] = word_in[DATA_W-1-g];
  end

  assign word_out = enable ? mirrored : word_in;

endmodule

// File: rtl/bfu_field_decode.sv
module bfu_field_decode #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [SEL_W-1:0]  start,
  input  logic [SEL_W-1:0]  width,
  output logic              start_ok,
  output logic              width_nz,
  output logic [CNT_W-1:0]  eff_width,
  output logic [IDX_W-1:0]  shamt,
  output logic [IDX_W-1:0]  sign_idx,
  output logic [DATA_W-1:0] low_mask,
  output logic [DATA_W-1:0] place_mask
);

  int eff_i;
  int sign_i;

  always_comb begin
    eff_i  = bfu_pkg::bfu_eff_width(int'(start), int'(width), DATA_W);
    sign_i = bfu_pkg::bfu_sign_index(int'(start), eff_i, DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      low_mask[i] = (i < eff_i);
    end
  end

  assign start_ok   = (int'(start) < DATA_W);
  assign width_nz   = (width != '0);
  assign eff_width  = CNT_W'(eff_i);
  assign sign_idx   = IDX_W'(sign_i);
  assign shamt      = start[IDX_W-1:0];
  assign place_mask = start_ok ? (low_mask << shamt) : '0;

endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic              signed_en,
  input  logic              start_ok,
  input  logic              width_nz,
  input  logic [IDX_W-1:0]  shamt,
  input  logic [IDX_W-1:0]  sign_idx,
  input  logic [DATA_W-1:0] low_mask,
  output logic              sign_bit,
  output logic [DATA_W-1:0] field_out
);

  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] field_bits;
  logic              fill_en;

  assign shifted    = start_ok ? (src >> shamt) : '0;
  assign field_bits = shifted & low_mask;
  assign sign_bit   = src[sign_idx];
  assign fill_en    = signed_en & width_nz & sign_bit;
  assign field_out  = fill_en ? (field_bits | ~low_mask) : field_bits;

endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] bits_in,
  input  logic [DATA_W-1:0] base_in,
  input  logic [IDX_W-1:0]  shamt,
  input  logic [DATA_W-1:0] place_mask,
  output logic [DATA_W-1:0] merged
);

  logic [DATA_W-1:0] placed;

  assign placed = bits_in << shamt;
  assign merged = (base_in & ~place_mask) | (placed & place_mask);

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic              op_insert,
  input  logic              signed_en,
  input  logic              reverse_en,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] ctrl_b,
  input  logic [DATA_W-1:0] opnd_c,
  output logic [DATA_W-1:0] result,
  output logic              valid_out
);

  import bfu_pkg::*;

  bfu_op_e           op_sel;
  logic [SEL_W-1:0]  fld_start;
  logic [SEL_W-1:0]  fld_width;
  logic              start_ok;
  logic              width_nz;
  logic [CNT_W-1:0]  eff_width;
  logic [IDX_W-1:0]  shamt;
  logic [IDX_W-1:0]  sign_idx;
  logic [DATA_W-1:0] low_mask;
  logic [DATA_W-1:0] place_mask;
  logic [DATA_W-1:0] ext_src;
  logic [DATA_W-1:0] ext_value;
  logic              ext_sign;
  logic [DATA_W-1:0] ins_value;
  logic [DATA_W-1:0] next_result;

  assign op_sel    = bfu_op_e'(op_insert);
  assign fld_start = ctrl_b[SEL_W-1:0];
  assign fld_width = ctrl_b[2*SEL_W-1:SEL_W];

  bfu_field_decode #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_decode (
    .start      (fld_start),
    .width      (fld_width),
    .start_ok   (start_ok),
    .width_nz   (width_nz),
    .eff_width  (eff_width),
    .shamt      (shamt),
    .sign_idx   (sign_idx),
    .low_mask   (low_mask),
    .place_mask (place_mask)
  );

  bfu_bit_reverse #(.DATA_W(DATA_W)) u_reverse (
    .enable   (reverse_en),
    .word_in  (opnd_a),
    .word_out (ext_src)
  );

  bfu_extract #(.DATA_W(DATA_W)) u_extract (
    .src       (ext_src),
    .signed_en (signed_en),
    .start_ok  (start_ok),
    .width_nz  (width_nz),
    .shamt     (shamt),
    .sign_idx  (sign_idx),
    .low_mask  (low_mask),
    .sign_bit  (ext_sign),
    .field_out (ext_value)
  );

  bfu_insert #(.DATA_W(DATA_W)) u_insert (
    .bits_in    (opnd_a),
    .base_in    (opnd_c),
    .shamt      (shamt),
    .place_mask (place_mask),
    .merged     (ins_value)
  );

  assign next_result = (op_sel == BFU_OP_INSERT) ? ins_value : ext_value;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      result    <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) result <= next_result;
    end
  end

  // Unsigned extract: nothing set outside the decoded field
  p_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_insert && !signed_en) |-> ((ext_value & ~low_mask) == '0));

  // Signed extract with sign bit set fills the top of the word
  p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !op_insert && signed_en && width_nz && ext_sign)
      |=> result[DATA_W-1]);

  // Insert keeps base bits outside the placed field
  p_keep_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_insert |-> ((ins_value & ~place_mask) == (opnd_c & ~place_mask)));

  // Zero width extract gives zero
  p_zero_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !op_insert && !width_nz) |=> (result == '0));

  // Empty field (zero width or start out of range) on insert returns C
  p_empty_insert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op_insert && (!width_nz || !start_ok))
      |=> (result == $past(opnd_c)));

  // Unsigned extract from an out of range start gives zero
  p_far_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && !op_insert && !signed_en && !start_ok) |=> (result == '0));

  // Truncated width never exceeds the room left above the start
  p_truncate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> (int'(eff_width) + int'(fld_start) <= DATA_W));

  // Strobe lags the input by one clock; result holds when idle
  p_valid_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(result));

endmodule

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic        op_insert = 1'b0;
  logic        signed_en = 1'b0;
  logic        reverse_en = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] ctrl_b = '0;
  logic [31:0] opnd_c = '0;
  logic [31:0] result;
  logic        valid_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_unit dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_in   (valid_in),
    .op_insert  (op_insert),
    .signed_en  (signed_en),
    .reverse_en (reverse_en),
    .opnd_a     (opnd_a),
    .ctrl_b     (ctrl_b),
    .opnd_c     (opnd_c),
    .result     (result),
    .valid_out  (valid_out)
  );

  // Bit-by-bit restatement of the requirements
  function automatic logic [31:0] ref_model(bit ins, bit sgn, bit rev,
      logic [31:0] a, logic [31:0] b, logic [31:0] c);
    int start = int'(b[7:0]);
    int width = int'(b[15:8]);
    int got = 0;
    logic [31:0] src;
    logic [31:0] r;
    logic top;
    if (ins) begin
      r = c;
      for (int i = 0; i < width; i++)
        if (start + i < 32) r[start+i] = a[i];
      return r;
    end
    for (int i = 0; i < 32; i++) src[i] = rev ? a[31-i] : a[i];
    r = '0;
    for (int i = 0; i < width; i++)
      if (start + i < 32) begin
        r[i] = src[start+i];
        got++;
      end
    if (sgn && width != 0) begin
      top = (got == 0) ? src[31] : src[start+got-1];
      for (int i = got; i < 32; i++) r[i] = top;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", req, got, exp);
    end
  endtask

  // One operation: drive at a falling edge, sample at the next falling edge
  task automatic run_op(string req, bit ins, bit sgn, bit rev,
      logic [31:0] a, logic [31:0] b, logic [31:0] c, output logic [31:0] got);
    @(negedge clk);
    valid_in = 1'b1; op_insert = ins; signed_en = sgn; reverse_en = rev;
    opnd_a = a; ctrl_b = b; opnd_c = c;
    @(negedge clk);
    valid_in = 1'b0;
    check({req, " strobe"}, {31'd0, valid_out}, 32'd1);
    got = result;
  endtask

  task automatic op_check(string req, bit ins, bit sgn, bit rev,
      logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [31:0] got;
    run_op(req, ins, sgn, rev, a, b, c, got);
    check(req, got, ref_model(ins, sgn, rev, a, b, c));
  endtask

  task automatic t_reset;
    check("R10 result", result, 32'd0);
    check("R10 valid_out", {31'd0, valid_out}, 32'd0);
  endtask

  task automatic t_unsigned;
    op_check("R2", 0, 0, 0, 32'hDEAD_BEEF, 32'h0000_0804, '0);
    op_check("R2", 0, 0, 0, 32'h8000_00FF, 32'h0000_0500, '0);
    check("R2 literal", result, 32'h0000_001F);
    op_check("R2", 0, 0, 0, 32'hF000_0000, 32'h0000_041C, '0);
    check("R2 literal top", result, 32'h0000_000F);
  endtask

  task automatic t_signed;
    op_check("R3", 0, 1, 0, 32'h0000_0F00, 32'h0000_0408, '0);
    check("R3 literal", result, 32'hFFFF_FFFF);
    op_check("R3", 0, 1, 0, 32'h0000_0700, 32'h0000_0408, '0);
    check("R3 literal pos", result, 32'h0000_0007);
    op_check("R3", 0, 1, 0, 32'h1234_A5C3, 32'h0000_0C06, '0);
  endtask

  task automatic t_reverse;
    op_check("R4", 0, 0, 1, 32'h0000_0001, 32'h0000_201F, '0);
    check("R4 literal", result, 32'h0000_0001);
    op_check("R4", 0, 0, 1, 32'h1234_5678, 32'h0000_2000, '0);
    check("R4 literal full", result, 32'h1E6A_2C48);
    op_check("R4", 0, 1, 1, 32'h0000_0003, 32'h0000_021E, '0);
    op_check("R4 insert unaffected", 1, 0, 1, 32'h0000_00AB, 32'h0000_0810, 32'h5555_5555);
    check("R4 literal insert", result, 32'h55AB_5555);
  endtask

  task automatic t_insert;
    op_check("R5", 1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0404, 32'h0000_0000);
    check("R5 literal", result, 32'h0000_00F0);
    op_check("R5", 1, 1, 0, 32'h0000_0012, 32'h0000_0300, 32'hAAAA_AAAA);
    check("R5 literal low", result, 32'hAAAA_AAAA);
    op_check("R5", 1, 0, 0, 32'hCAFE_F00D, 32'h0000_1009, 32'h5555_5555);
  endtask

  task automatic t_control_upper;
    logic [31:0] g0, g1;
    run_op("R1", 0, 1, 0, 32'h89AB_CDEF, 32'h0000_0A03, '0, g0);
    run_op("R1", 0, 1, 0, 32'h89AB_CDEF, 32'hFFFF_0A03, '0, g1);
    check("R1 upper ignored extract", g1, g0);
    check("R1 extract value", g0, ref_model(0, 1, 0, 32'h89AB_CDEF, 32'h0000_0A03, '0));
    run_op("R1", 1, 0, 0, 32'h0000_0FFF, 32'h5A5A_0C10, 32'h0, g1);
    check("R1 upper ignored insert", g1, 32'h0FFF_0000);
  endtask

  task automatic t_zero_width;
    op_check("R6", 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0000, '0);
    op_check("R6", 0, 1, 0, 32'hFFFF_FFFF, 32'h0000_0010, '0);
    check("R6 signed literal", result, 32'h0);
    op_check("R6", 1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0005, 32'h1357_9BDF);
    check("R6 insert literal", result, 32'h1357_9BDF);
  endtask

  task automatic t_truncate;
    op_check("R7", 0, 0, 0, 32'hF000_0000, 32'h0000_101C, '0);
    check("R7 literal", result, 32'h0000_000F);
    op_check("R7", 0, 1, 0, 32'h8000_0000, 32'h0000_FF1F, '0);
    check("R7 signed literal", result, 32'hFFFF_FFFF);
    op_check("R7", 1, 0, 0, 32'hFFFF_FFFF, 32'h0000_401E, 32'h0);
    check("R7 insert literal", result, 32'hC000_0000);
  endtask

  task automatic t_far_start;
    op_check("R8", 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0820, '0);
    check("R8 unsigned literal", result, 32'h0);
    op_check("R8", 0, 1, 0, 32'h8000_0000, 32'h0000_0120, '0);
    check("R8 signed literal", result, 32'hFFFF_FFFF);
    op_check("R8", 0, 1, 0, 32'h7FFF_FFFF, 32'h0000_08FF, '0);
    check("R8 signed clear literal", result, 32'h0);
    op_check("R8", 1, 0, 0, 32'hFFFF_FFFF, 32'h0000_0821, 32'h2468_ACE0);
    check("R8 insert literal", result, 32'h2468_ACE0);
  endtask

  task automatic t_timing;
    logic [31:0] held;
    op_check("R9", 0, 0, 0, 32'hABCD_1234, 32'h0000_1004, '0);
    held = result;
    @(negedge clk);
    opnd_a = 32'hFFFF_FFFF; ctrl_b = 32'h0000_2000; op_insert = 1'b0;
    @(negedge clk);
    check("R9 idle strobe", {31'd0, valid_out}, 32'd0);
    check("R9 hold", result, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_reverse();
    t_insert();
    t_control_upper();
    t_zero_width();
    t_truncate();
    t_far_start();
    t_timing();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule